// File: doc/BRIEF.md
# Memory-Mapped Data Address Decoder

This block is the unified data store of a small 16-bit machine. It presents one 15-bit word address space that is split into three regions of unequal size: a general-purpose RAM in the lower half, a frame-buffer window in the next quarter, and a single read-only word that holds the code of the key currently held on an external keyboard. Every address above that keyboard word is invalid.

Each cycle the block decodes the address and enables the write port of at most one region. It also steers the selected region's word back to the read port. Reads are combinational: the addressed word appears in the same cycle. A write made with the load strobe high lands on the clock edge and can be read back from the following cycle.

The keyboard code comes from outside the block. It is captured into a register on every clock, so a read of the keyboard word returns the code that was present at the previous edge. The RAM and window regions decode their full address ranges. The storage built behind each region can be made smaller by a parameter. When it is smaller, the upper offset bits inside that region are ignored and the stored words alias across the region.

Top module: `mmap_data_mem`

## Requirements
- R1: Addresses 0x0000 to 0x3FFF access the general RAM, which returns the last word written to the same RAM location.
- R2: Addresses 0x4000 to 0x5FFF access the frame-buffer window, which is separate storage from the RAM.
- R3: A read of address 0x6000 returns the key code sampled at the previous rising clock edge. The captured value is 0 while reset is asserted, so the word reads 0 in reset.
- R4: A read is combinational: a change of address changes the read data within the same cycle, with no clock edge in between.
- R5: A write to RAM or window with load high is not visible before the clock edge. The new value is returned from the next cycle onward.
- R6: Writes to 0x6000 and to any invalid address (0x6001 to 0x7FFF) change no stored word in any region.
- R7: A read of any invalid address (0x6001 to 0x7FFF) returns 0.
- R8: Address bits 14 and 13 select the region: 00 and 01 select RAM, 10 selects the window, and 11 selects the keyboard word or an invalid address. At most one region's write enable is active in any cycle.
- R9: When the built storage is smaller than its region, a RAM word is addressed by addr[RAM_AW-1:0] and a window word by addr[SCR_AW-1:0]. The higher offset bits are ignored.
- R10: With load low, no stored word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W (15) | Word address for both read and write |
| wdata | input | DATA_W (16) | Word to be written |
| load | input | 1 | Write strobe; the write commits at the next rising edge |
| key_code | input | DATA_W (16) | Code of the pressed key, 0 when no key is pressed |
| rdata | output | DATA_W (16) | Word at the current address; 0 for invalid addresses |

## Verification
The bench builds the block with RAM_AW=6 and SCR_AW=5. This gives 64 RAM words and 32 window words, small enough to fill and to alias within a short run.

These sizes let writes at the far end of each region, and writes at invalid addresses, land on low offsets whose values the bench already knows. Aliasing (R9) and the no-effect cases (R6) can therefore be observed at the read port. The region boundaries 0x3FFF/0x4000, 0x5FFF/0x6000 and 0x6000/0x6001 are exercised directly, and a random sweep then mixes all regions against the reference model.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  // Region selected by the top two address bits plus the keyboard match
  typedef enum logic [1:0] {
    RG_RAM = 2'd0,
    RG_SCR = 2'd1,
    RG_KBD = 2'd2,
    RG_BAD = 2'd3
  } region_e;

endpackage

// File: rtl/mmap_rst_sync.sv
module mmap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/mmap_decode.sv
module mmap_decode
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  output region_e           region,
  output logic              ram_we,
  output logic              scr_we
);

  localparam int TOP   = ADDR_W - 1;
  localparam int SUB   = ADDR_W - 2;
  localparam int OFF_W = ADDR_W - 2;

  logic [1:0]       sel;
  logic [OFF_W-1:0] off;
  logic             kbd_hit;

  assign sel     = addr[TOP:SUB];
  assign off     = addr[OFF_W-1:0];
  assign kbd_hit = (off == '0);

  always_comb begin
    unique case (sel)
      2'b00, 2'b01: region = RG_RAM;
      2'b10:        region = RG_SCR;
      default:      region = kbd_hit ? RG_KBD : RG_BAD;
    endcase
  end

  always_comb begin
    ram_we = 1'b0;
    scr_we = 1'b0;
    if (load) begin
      ram_we = (region == RG_RAM);
      scr_we = (region == RG_SCR);
    end
  end

endmodule

// File: rtl/mmap_store.sv
module mmap_store #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[a] <= wd;
    end
  end

  assign rd = mem_q[a];

endmodule

// File: rtl/mmap_keylatch.sv
module mmap_keylatch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] code_in,
  output logic [DW-1:0] code_q
);

  logic [DW-1:0] code_d;

  always_comb begin
    code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/mmap_data_mem.sv
module mmap_data_mem
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int RAM_AW = 10,
  parameter int SCR_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic [DATA_W-1:0] key_code,
  output logic [DATA_W-1:0] rdata
);

  localparam int NSTORE = 2;

  logic              rst_sync_n;
  region_e           region;
  logic              ram_we;
  logic              scr_we;
  logic [DATA_W-1:0] kbd_q;
  logic [DATA_W-1:0] ram_rd;
  logic [DATA_W-1:0] scr_rd;
  logic [NSTORE-1:0] st_we;
  logic [DATA_W-1:0] st_rd [NSTORE];

  mmap_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  mmap_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .load   (load),
    .region (region),
    .ram_we (ram_we),
    .scr_we (scr_we)
  );

  assign st_we = {scr_we, ram_we};

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam int AW = (g == 0) ? RAM_AW : SCR_AW;
    mmap_store #(.AW(AW), .DW(DATA_W)) u_mem (
      .clk (clk),
      .we  (st_we[g]),
      .a   (addr[AW-1:0]),
      .wd  (wdata),
      .rd  (st_rd[g])
    );
  end

  assign ram_rd = st_rd[0];
  assign scr_rd = st_rd[1];

  mmap_keylatch #(.DW(DATA_W)) u_kbd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_in (key_code),
    .code_q  (kbd_q)
  );

  always_comb begin
    unique case (region)
      RG_RAM:  rdata = ram_rd;
      RG_SCR:  rdata = scr_rd;
      RG_KBD:  rdata = kbd_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mmap_data_mem_chk.sv
module mmap_data_mem_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              load,
  input logic [DATA_W-1:0] key_code,
  input logic [DATA_W-1:0] rdata,
  input logic              ram_we,
  input logic              scr_we
);

  localparam int TOP = ADDR_W - 1;
  localparam int SUB = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] KBD_A = {2'b11, {(ADDR_W-2){1'b0}}};

  // R8
  onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ram_we, scr_we}));

  // R6
  kbd_bad_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr[TOP:SUB] == 2'b11) |-> (!ram_we && !scr_we));

  // R10
  noload_nowe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load |-> (!ram_we && !scr_we));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr[TOP:SUB] == 2'b11 && addr[SUB-1:0] != '0) |-> (rdata == '0));

  // R3
  kbd_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr == KBD_A && $past(rst_sync_n)) |-> (rdata == $past(key_code)));

  // R5
  ram_wr_vis_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && !addr[TOP]) |=> (addr != $past(addr) || rdata == $past(wdata)));

  // R2
  scr_wr_vis_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && addr[TOP:SUB] == 2'b10) |=> (addr != $past(addr) || rdata == $past(wdata)));

endmodule

bind mmap_data_mem mmap_data_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .wdata      (wdata),
  .load       (load),
  .key_code   (key_code),
  .rdata      (rdata),
  .ram_we     (ram_we),
  .scr_we     (scr_we)
);

// File: tb/tb_mmap_data_mem.sv
module tb_mmap_data_mem;

  localparam int RAM_AW = 6;
  localparam int SCR_AW = 5;
  localparam int RMASK  = (1 << RAM_AW) - 1;
  localparam int SMASK  = (1 << SCR_AW) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] addr;
  logic [15:0] wdata;
  logic        load;
  logic [15:0] key_code;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] ram_m [int];
  logic [15:0] scr_m [int];
  logic [15:0] kbd_ref = 16'h0000;

  always #5 clk = ~clk;

  mmap_data_mem #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .load(load), .key_code(key_code), .rdata(rdata)
  );

  task automatic expect_now(input string tag);
    int a;
    bit known;
    logic [15:0] ev;
    string t;
    a = int'(addr);
    known = 1'b1;
    ev = 16'h0;
    if (a < 16'h4000) begin
      t = "R1";
      if (ram_m.exists(a & RMASK)) ev = ram_m[a & RMASK]; else known = 1'b0;
    end else if (a < 16'h6000) begin
      t = "R2";
      if (scr_m.exists((a - 16'h4000) & SMASK)) ev = scr_m[(a - 16'h4000) & SMASK];
      else known = 1'b0;
    end else if (a == 16'h6000) begin
      t = "R3";
      ev = kbd_ref;
    end else begin
      t = "R7";
      ev = 16'h0;
    end
    if (tag != "") t = tag;
    if (known) begin
      checks++;
      if (rdata !== ev) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, addr, rdata, ev);
      end
    end
  endtask

  task automatic model_edge();
    int a;
    a = int'(addr);
    if (rst_n) kbd_ref = key_code;
    else kbd_ref = 16'h0;
    if (load) begin
      if (a < 16'h4000) ram_m[a & RMASK] = wdata;
      else if (a < 16'h6000) scr_m[(a - 16'h4000) & SMASK] = wdata;
    end
  endtask

  task automatic cyc(input logic [14:0] a, input logic [15:0] d, input logic l,
                     input logic [15:0] k, input string tag);
    @(negedge clk);
    addr = a; wdata = d; load = l; key_code = k;
    #2;
    expect_now(tag);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 15'h0; wdata = 16'h0; load = 1'b0; key_code = 16'h0;
    // R3: keyboard word reads 0 in reset; R7: invalid reads 0
    cyc(15'h6000, 16'h0, 1'b0, 16'h0, "R3");
    cyc(15'h7FFF, 16'h0, 1'b0, 16'h0, "R7");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(15'h6000, 16'h0, 1'b0, 16'h0, "R3");

    // R1 basic RAM, R5 write timing
    cyc(15'h0005, 16'hA5A5, 1'b1, 16'h0, "R1");
    cyc(15'h0005, 16'h1234, 1'b1, 16'h0, "R5");
    cyc(15'h0005, 16'h0, 1'b0, 16'h0, "R5");
    cyc(15'h3FFF, 16'h3F3F, 1'b1, 16'h0, "R1");
    cyc(15'h3FFF, 16'h0, 1'b0, 16'h0, "R1");

    // R4 combinational read
    cyc(15'h0006, 16'h0666, 1'b1, 16'h0, "R4");
    @(negedge clk);
    addr = 15'h0005; load = 1'b0;
    #2; expect_now("R4");
    addr = 15'h0006;
    #1; expect_now("R4");
    @(posedge clk); model_edge();

    // R2 window boundaries
    cyc(15'h4000, 16'hBEEF, 1'b1, 16'h0, "R2");
    cyc(15'h5FFF, 16'hC0DE, 1'b1, 16'h0, "R2");
    cyc(15'h4000, 16'h0, 1'b0, 16'h0, "R2");
    cyc(15'h5FFF, 16'h0, 1'b0, 16'h0, "R2");

    // R8 regions separate
    cyc(15'h0000, 16'h1111, 1'b1, 16'h0, "R8");
    cyc(15'h4000, 16'h2222, 1'b1, 16'h0, "R8");
    cyc(15'h0000, 16'h0, 1'b0, 16'h0, "R8");
    cyc(15'h4000, 16'h0, 1'b0, 16'h0, "R8");

    // R6 keyboard and invalid writes ignored
    cyc(15'h0001, 16'h0101, 1'b1, 16'h0, "R6");
    cyc(15'h4001, 16'h0202, 1'b1, 16'h0, "R6");
    cyc(15'h003F, 16'h3F00, 1'b1, 16'h0, "R6");
    cyc(15'h6000, 16'hFFFF, 1'b1, 16'h0041, "R6");
    cyc(15'h6000, 16'h0, 1'b0, 16'h0041, "R6");
    cyc(15'h6001, 16'h9999, 1'b1, 16'h0041, "R6");
    cyc(15'h7FFF, 16'h8888, 1'b1, 16'h0041, "R6");
    cyc(15'h0001, 16'h0, 1'b0, 16'h0041, "R6");
    cyc(15'h4001, 16'h0, 1'b0, 16'h0041, "R6");
    cyc(15'h003F, 16'h0, 1'b0, 16'h0041, "R6");
    cyc(15'h5FFF, 16'h0, 1'b0, 16'h0041, "R6");
    cyc(15'h6000, 16'h0, 1'b0, 16'h0041, "R6");

    // R7 invalid reads
    cyc(15'h6001, 16'h0, 1'b0, 16'h0041, "R7");
    cyc(15'h7000, 16'h0, 1'b0, 16'h0041, "R7");
    cyc(15'h7FFF, 16'h0, 1'b0, 16'h0041, "R7");

    // R3 key code capture one edge late
    cyc(15'h6000, 16'h0, 1'b0, 16'h0083, "R3");
    cyc(15'h6000, 16'h0, 1'b0, 16'h0000, "R3");
    cyc(15'h6000, 16'h0, 1'b0, 16'h0000, "R3");

    // R9 aliasing inside regions
    cyc(15'h0007, 16'h7777, 1'b1, 16'h0, "R9");
    cyc(15'h0047, 16'h0, 1'b0, 16'h0, "R9");
    cyc(15'h3FC7, 16'h0, 1'b0, 16'h0, "R9");
    cyc(15'h4003, 16'h4343, 1'b1, 16'h0, "R9");
    cyc(15'h4023, 16'h0, 1'b0, 16'h0, "R9");
    cyc(15'h5FE3, 16'h0, 1'b0, 16'h0, "R9");

    // R10 load low leaves storage
    cyc(15'h0005, 16'hDEAD, 1'b0, 16'h0, "R10");
    cyc(15'h0005, 16'h0, 1'b0, 16'h0, "R10");
    cyc(15'h4000, 16'hDEAD, 1'b0, 16'h0, "R10");
    cyc(15'h4000, 16'h0, 1'b0, 16'h0, "R10");

    // random sweep across all regions
    for (int i = 0; i < 400; i++) begin
      logic [14:0] ra;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1: ra = 15'($urandom_range(0, 16'h3FFF));
        2, 3: ra = 15'($urandom_range(16'h4000, 16'h5FFF));
        4:    ra = 15'h6000;
        default: ra = 15'($urandom_range(16'h6000, 16'h7FFF));
      endcase
      cyc(ra, 16'($urandom), 1'($urandom_range(0, 1)), 16'($urandom_range(0, 255)), "");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule